// File: doc/BRIEF.md
# SD Card SPI-Mode Command Issuer

This block issues a single command to an MMC/SD card running in SPI mode and returns the card's one-byte R1 status. The caller supplies a 6-bit command index and a 32-bit argument and pulses a start input. The block then builds a seven-byte frame, computes its CRC7 checksum on the fly, and passes the bytes one at a time to an external SPI shifter. It then polls the card for the R1 byte and reports it together with a 2-bit outcome code.

The shifter is reached only through a byte exchange handshake. The block raises a request and presents a transmit byte. The shifter answers with a one-cycle acknowledge and carries the byte it received back on the same cycle. Chip select is driven low before the first frame byte goes out. It stays low after the result is reported, so that a data phase handled elsewhere can follow. It is released only when the caller signals that the transaction has ended.

A second entry point provides the power-up wake sequence. It sends eighteen 0xFF bytes (144 clocks) while chip select stays inactive.

Top module: `sd_cmd_issuer`

## Requirements
- R1: After reset, cs_n is 1 and busy, xfer_req and done are all 0.
- R2: A command sends exactly seven bytes in this order: 0xFF, then {2'b01, cmd_index}, then cmd_arg most significant byte first, then the check byte.
- R3: The check byte is {crc, 1'b1}. Here crc is the 7-bit CRC of the five bytes that follow the filler, with generator x^7+x^3+1, an initial value of zero, and bits taken most significant first. For index 0 with argument 0 the check byte is 0x95, and for index 8 with argument 0x1AA it is 0x87.
- R4: After the frame the block polls by sending 0xFF. It never accepts the first polled byte, even when its bit 7 is clear. It accepts the first later byte with bit 7 clear and stops polling at that byte.
- R5: Polling stops after at most 8 bytes. If no byte is accepted, the reported R1 is the eighth byte received.
- R6: The status is coded by priority. A value of 1 (no card) is given when R1 is 0xFF. Otherwise 2 (CRC error) is given when R1 bit 3 is set. Otherwise 3 (general error) is given when any bit other than bit 0 is set. Otherwise the status is 0 (OK).
- R7: done is a one-cycle pulse. On that cycle r1_out and status_out carry the result.
- R8: cs_n is 0 for every byte of a command, including the filler. It stays 0 after done until txn_end is seen, and it is 1 on the cycle after that.
- R9: init_start, given while idle, sends eighteen 0xFF bytes with cs_n at 1. After that busy returns to 0 and no done is produced.
- R10: cmd_start and init_start have no effect while busy is 1. This includes the wait for txn_end.
- R11: While xfer_req is 1 and xfer_ack is 0, xfer_req stays 1 and xfer_tx stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Starts a command when idle |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| init_start | input | 1 | Starts the wake sequence when idle |
| txn_end | input | 1 | Releases chip select after done |
| busy | output | 1 | Block is not idle |
| done | output | 1 | Result valid pulse |
| r1_out | output | 8 | Reported R1 byte |
| status_out | output | 2 | 0 OK, 1 no card, 2 CRC error, 3 general error |
| cs_n | output | 1 | Card chip select, active low |
| xfer_req | output | 1 | Byte exchange request |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | Exchange complete, one cycle |
| xfer_rx | input | 8 | Byte received, valid with xfer_ack |

## Verification
Some properties are checked by assertions on every cycle. These are that the transmit byte is held through a stalled exchange, that done lasts one cycle, that chip select is low when done is given and high during the wake sequence, that the block is quiet when idle, and that the poll counter stays in range. The frame contents and the CRC value come only from the bench's scenarios. So do the refusal of the first polled byte, the timeout result, the priority of the status code and the ignored start pulses. The bench compares each exchanged byte and chip-select level against a queue of expected items, and it flags any exchange that was not expected.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    localparam logic [7:0] FILLER_BYTE = 8'hFF;
    localparam logic [1:0] CMD_PREFIX  = 2'b01;
    localparam logic [6:0] CRC7_GEN    = 7'h09;
    localparam int         FRAME_LEN   = 7;
    localparam int         R1_IDLE_POS = 0;
    localparam int         R1_CRC_POS  = 3;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_NOCARD = 2'd1,
        RES_CRCERR = 2'd2,
        RES_GENERR = 2'd3
    } sdc_status_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAKE,
        PH_FRAME,
        PH_POLL,
        PH_HOLD
    } sdc_phase_e;

    typedef struct packed {
        logic [7:0]  r1;
        sdc_status_e status;
    } sdc_result_t;

    // Advance the CRC7 register by one byte, most significant bit first.
    function automatic logic [6:0] crc7_byte(input logic [6:0] cur, input logic [7:0] data);
        logic [6:0] r;
        logic       fb;
        r = cur;
        for (int i = 7; i >= 0; i--) begin
            fb = r[6] ^ data[i];
            r  = {r[5:0], 1'b0};
            if (fb) r = r ^ CRC7_GEN;
        end
        return r;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       en,
    input  logic [7:0] din,
    output logic [6:0] crc
);
    logic [6:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) acc_q <= '0;
        else if (en)    acc_q <= crc7_byte(acc_q, din);
    end

    assign crc = acc_q;

endmodule

// File: rtl/sdc_frame_mux.sv
module sdc_frame_mux
    import sdc_pkg::*;
(
    input  logic [5:0]  index,
    input  logic [31:0] arg,
    input  logic [6:0]  crc,
    input  logic [2:0]  sel,
    output logic [7:0]  byte_out
);
    always_comb begin
        unique case (sel)
            3'd0:    byte_out = FILLER_BYTE;
            3'd1:    byte_out = {CMD_PREFIX, index};
            3'd2:    byte_out = arg[31:24];
            3'd3:    byte_out = arg[23:16];
            3'd4:    byte_out = arg[15:8];
            3'd5:    byte_out = arg[7:0];
            3'd6:    byte_out = {crc, 1'b1};
            default: byte_out = FILLER_BYTE;
        endcase
    end

endmodule

// File: rtl/sdc_r1_classify.sv
module sdc_r1_classify
    import sdc_pkg::*;
(
    input  logic [7:0]  r1,
    output sdc_status_e status
);
    logic [7:0] err_mask;

    always_comb begin
        err_mask              = 8'hFF;
        err_mask[R1_IDLE_POS] = 1'b0;
        if (r1 == FILLER_BYTE)          status = RES_NOCARD;
        else if (r1[R1_CRC_POS])        status = RES_CRCERR;
        else if ((r1 & err_mask) != '0) status = RES_GENERR;
        else                            status = RES_OK;
    end

endmodule

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer
    import sdc_pkg::*;
#(
    parameter int WAKE_BYTES = 18,
    parameter int POLL_MAX   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_start,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic        init_start,
    input  logic        txn_end,
    output logic        busy,
    output logic        done,
    output logic [7:0]  r1_out,
    output logic [1:0]  status_out,
    output logic        cs_n,
    output logic        xfer_req,
    output logic [7:0]  xfer_tx,
    input  logic        xfer_ack,
    input  logic [7:0]  xfer_rx
);
    localparam int CNT_MAX = max3(WAKE_BYTES, FRAME_LEN, POLL_MAX);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    sdc_phase_e  phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [5:0]  idx_q;
    logic [31:0] arg_q;
    sdc_result_t res_q;
    logic        done_q;

    logic [6:0]  crc_val;
    logic [7:0]  frame_byte;
    sdc_status_e rx_status;
    logic        crc_clr, crc_en;
    logic        poll_accept, poll_last;

    sdc_crc7 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .en  (crc_en),
        .din (frame_byte),
        .crc (crc_val)
    );

    sdc_frame_mux u_mux (
        .index    (idx_q),
        .arg      (arg_q),
        .crc      (crc_val),
        .sel      (cnt_q[2:0]),
        .byte_out (frame_byte)
    );

    sdc_r1_classify u_cls (
        .r1     (xfer_rx),
        .status (rx_status)
    );

    assign crc_clr     = (phase_q == PH_IDLE) && cmd_start;
    assign crc_en      = (phase_q == PH_FRAME) && xfer_ack &&
                         (cnt_q >= CNT_W'(1)) && (cnt_q <= CNT_W'(5));
    assign poll_accept = (cnt_q != '0) && !xfer_rx[7];
    assign poll_last   = (cnt_q == CNT_W'(POLL_MAX - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            arg_q   <= '0;
            res_q   <= '{r1: 8'h00, status: RES_OK};
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (cmd_start) begin
                        idx_q   <= cmd_index;
                        arg_q   <= cmd_arg;
                        phase_q <= PH_FRAME;
                    end else if (init_start) begin
                        phase_q <= PH_WAKE;
                    end
                end
                PH_WAKE: begin
                    if (xfer_ack) begin
                        if (cnt_q == CNT_W'(WAKE_BYTES - 1)) begin
                            cnt_q   <= '0;
                            phase_q <= PH_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_FRAME: begin
                    if (xfer_ack) begin
                        if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin
                            cnt_q   <= '0;
                            phase_q <= PH_POLL;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_POLL: begin
                    if (xfer_ack) begin
                        if (poll_accept || poll_last) begin
                            res_q   <= '{r1: xfer_rx, status: rx_status};
                            done_q  <= 1'b1;
                            cnt_q   <= '0;
                            phase_q <= PH_HOLD;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    if (txn_end) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy       = (phase_q != PH_IDLE);
        xfer_req   = (phase_q == PH_WAKE) || (phase_q == PH_FRAME) || (phase_q == PH_POLL);
        xfer_tx    = (phase_q == PH_FRAME) ? frame_byte : FILLER_BYTE;
        cs_n       = !((phase_q == PH_FRAME) || (phase_q == PH_POLL) || (phase_q == PH_HOLD));
        done       = done_q;
        r1_out     = res_q.r1;
        status_out = res_q.status;
    end

    // R1: an idle block neither selects the card nor requests bytes.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n && !xfer_req));

    // R11: a stalled exchange keeps its request and byte.
    p_tx_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

    // R7: done lasts one cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: the card stays selected when the result is reported.
    p_cs_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !cs_n);

    // R9: the wake sequence runs with the card deselected.
    p_wake_desel_r9: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WAKE) |-> cs_n);

    // R5: the poll counter never passes the poll limit.
    p_poll_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_POLL) |-> (cnt_q < CNT_W'(POLL_MAX)));

endmodule

// File: tb/sd_cmd_issuer_tb_top.sv
module sd_cmd_issuer_tb_top;

    typedef struct {
        logic [7:0] tx;
        logic       csn;
        logic [7:0] rx;
        string      req;
    } xitem_t;

    typedef struct {
        logic [7:0] r1;
        logic [1:0] st;
    } dres_t;

    typedef logic [7:0] rsp_t [8];

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_start = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic        init_start = 1'b0;
    logic        txn_end = 1'b0;
    logic        busy, done, cs_n, xfer_req;
    logic [7:0]  r1_out, xfer_tx;
    logic [1:0]  status_out;
    logic        xfer_ack = 1'b0;
    logic [7:0]  xfer_rx = 8'hFF;

    int checks = 0;
    int fails  = 0;
    xitem_t xq[$];
    dres_t  dq[$];

    always #2.5 clk = ~clk;

    sd_cmd_issuer dut_i (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_index(cmd_index),
        .cmd_arg(cmd_arg), .init_start(init_start), .txn_end(txn_end),
        .busy(busy), .done(done), .r1_out(r1_out), .status_out(status_out),
        .cs_n(cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
        .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Serial reference CRC over the whole 40-bit message.
    function automatic logic [7:0] ref_check_byte(input logic [39:0] msg);
        logic [6:0] s;
        logic       b;
        s = '0;
        for (int i = 39; i >= 0; i--) begin
            b = s[6] ^ msg[i];
            s = {s[5:0], 1'b0};
            s[0] = s[0] ^ b;
            s[3] = s[3] ^ b;
        end
        return {s, 1'b1};
    endfunction

    // Shifter model: variable ack latency, compares each exchange.
    initial begin
        int gap = 0;
        forever begin
            @(negedge clk);
            if (xfer_req === 1'b1) begin
                repeat (gap) @(negedge clk);
                gap = (gap + 1) % 3;
                if (xq.size() == 0) begin
                    chk(1'b0, "R10 unexpected exchange", {24'h0, xfer_tx}, 32'h0);
                    xfer_rx = 8'hFF;
                end else begin
                    xitem_t it;
                    it = xq.pop_front();
                    chk(xfer_tx == it.tx, it.req, {24'h0, xfer_tx}, {24'h0, it.tx});
                    chk(cs_n == it.csn, (it.csn ? "R9 cs level" : "R8 cs level"),
                        {31'h0, cs_n}, {31'h0, it.csn});
                    xfer_rx = it.rx;
                end
                xfer_ack = 1'b1;
                @(negedge clk);
                xfer_ack = 1'b0;
            end
        end
    end

    // Result monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done === 1'b1) begin
                if (dq.size() == 0) begin
                    chk(1'b0, "R9/R10 unexpected done", {24'h0, r1_out}, 32'h0);
                end else begin
                    dres_t d;
                    d = dq.pop_front();
                    chk(r1_out == d.r1, "R4 R5 r1 value", {24'h0, r1_out}, {24'h0, d.r1});
                    chk(status_out == d.st, "R6 status", {30'h0, status_out}, {30'h0, d.st});
                end
            end
        end
    end

    task automatic run_wake();
        for (int i = 0; i < 18; i++) xq.push_back('{8'hFF, 1'b1, 8'hFF, "R9 wake byte"});
        @(negedge clk); init_start = 1'b1;
        @(negedge clk); init_start = 1'b0;
        while (busy) @(negedge clk);
        chk(xq.size() == 0, "R9 wake count", xq.size(), 0);
        chk(cs_n == 1'b1, "R9 cs after wake", {31'h0, cs_n}, 1);
    endtask

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input rsp_t rsp, input bit poke);
        logic [7:0] fb [7];
        int k;
        dres_t d;
        fb[0] = 8'hFF;
        fb[1] = {2'b01, idx};
        fb[2] = arg[31:24]; fb[3] = arg[23:16]; fb[4] = arg[15:8]; fb[5] = arg[7:0];
        fb[6] = ref_check_byte({fb[1], arg});
        for (int i = 0; i < 7; i++)
            xq.push_back('{fb[i], 1'b0, 8'hFF, (i == 6) ? "R3 check byte" : "R2 frame byte"});
        k = 7;
        for (int i = 7; i >= 1; i--) if (!rsp[i][7]) k = i;
        for (int i = 0; i <= k; i++) xq.push_back('{8'hFF, 1'b0, rsp[i], "R4 poll byte"});
        d.r1 = rsp[k];
        if (d.r1 == 8'hFF)          d.st = 2'd1;
        else if (d.r1[3])           d.st = 2'd2;
        else if (d.r1[7:1] != 7'h0) d.st = 2'd3;
        else                        d.st = 2'd0;
        dq.push_back(d);
        @(negedge clk); cmd_index = idx; cmd_arg = arg; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
        chk(busy == 1'b1, "R7 busy after start", {31'h0, busy}, 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            cmd_index = ~idx; cmd_arg = ~arg; cmd_start = 1'b1; init_start = 1'b1;
            @(negedge clk); cmd_start = 1'b0; init_start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        chk(xq.size() == 0, "R4 R5 poll count", xq.size(), 0);
        @(negedge clk);
        chk(done == 1'b0, "R7 done width", {31'h0, done}, 0);
        if (poke) begin
            cmd_start = 1'b1; init_start = 1'b1;
            @(negedge clk); cmd_start = 1'b0; init_start = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b0 && busy == 1'b1, "R8 cs held", {30'h0, cs_n, busy}, 32'h1);
        chk(xfer_req == 1'b0, "R10 no request in hold", {31'h0, xfer_req}, 0);
        txn_end = 1'b1;
        @(negedge clk); txn_end = 1'b0;
        chk(cs_n == 1'b1 && busy == 1'b0, "R8 cs release", {30'h0, cs_n, busy}, 32'h2);
        repeat (4) @(negedge clk);
        chk(xfer_req == 1'b0, "R10 quiet after release", {31'h0, xfer_req}, 0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0 && xfer_req == 1'b0 && done == 1'b0,
            "R1 reset state", {28'h0, cs_n, busy, xfer_req, done}, 32'h8);
        chk(ref_check_byte({8'h40, 32'h0}) == 8'h95, "R3 ref CRC cmd0", 0, 32'h95);
        chk(ref_check_byte({8'h48, 32'h1AA}) == 8'h87, "R3 ref CRC cmd8", 0, 32'h87);
        run_wake();
        // R4: OK at second byte
        run_cmd(6'd0, 32'h0, '{8'hFF, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b0);
        // R4: first byte clear but refused
        run_cmd(6'd8, 32'h1AA, '{8'h00, 8'hFF, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b0);
        // R5 R6: no card
        run_cmd(6'd17, 32'h12345678, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b0);
        // R6: CRC error
        run_cmd(6'd55, 32'h0, '{8'hFF, 8'h09, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b0);
        // R6: CRC takes priority over illegal command
        run_cmd(6'd41, 32'h40000000, '{8'hFF, 8'hFF, 8'h0C, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b0);
        // R6: general error, R10 pokes while busy
        run_cmd(6'd16, 32'h200, '{8'hFF, 8'hFF, 8'hFF, 8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b1);
        // R5: timeout on a non-0xFF byte
        run_cmd(6'd58, 32'h0, '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h80}, 1'b0);
        // R2: full-width index and argument
        run_cmd(6'd63, 32'hDEADBEEF, '{8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b0);
        run_wake();
        chk(dq.size() == 0, "R7 all results seen", dq.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule